// File: doc/BRIEF.md
# Full-duplex SPI master with delayed receive capture

This block is a serial master for a four-wire full-duplex link. A host places a transmit word on a parallel port and pulses a start input. The block pulls its single active-low select low and generates the serial clock from the system clock. It shifts the frame out on txd, MSB first, while it shifts the answer in from rxd. When the frame is complete it deselects the slave, presents the received word and pulses a done output for one cycle.

Five configuration inputs are latched when a transfer is accepted: frame length, idle clock level, clock phase, clock half-period and receive capture delay. The capture delay moves the rxd sampling instant a few system clocks past each sampling edge of the serial clock. This absorbs board and pad delay on the returning data path, so the link can run at high bit rates without slowing the clock.

Top module: `spi_delay_master`

## Requirements
- R1: `cfg_len` gives the frame length in bits. A value below 4 is treated as 4 and a value above 16 as 16. Each transfer produces exactly twice that many serial clock edges while `ss_n` is low.
- R2: While idle, `sclk` rests at the level of `cfg_cpol` (0 = low, 1 = high) and `ss_n` is high.
- R3: With `cfg_cpha` = 0, the first bit is on txd from the cycle `ss_n` falls. Bits are sampled on the first, third, ... edges and txd changes on the second, fourth, ... edges, but not on the last one.
- R4: With `cfg_cpha` = 1, the master launches each bit on the first, third, ... edges and samples rxd on the second, fourth, ... edges.
- R5: Data leaves MSB first from the low `len` bits of `tx_word`. `rx_word` holds the received bits right-aligned in its low `len` bits, with zeros above them.
- R6: Each half-period of `sclk` lasts `cfg_div` system clocks, and the first edge comes `cfg_div` clocks after `ss_n` falls. A `cfg_div` below 2 acts as 2.
- R7: rxd is captured `cfg_rx_dly` system clocks (0 to 7) after each sampling edge. With 0, rxd is captured at the clock edge on which `sclk` toggles.
- R8: `done` is a single-cycle pulse that rises together with `ss_n`. `rx_word` changes only in that cycle. Counting from the clock that accepts start, `done` appears after max((2·len+1)·div, S+dly+1) clocks, where S is 2·len·div for phase 1 and (2·len−1)·div for phase 0.
- R9: `start` is accepted only while `busy` is low. A start pulse during a transfer has no effect on that transfer or on its result.
- R10: `ss_oe_n` is low exactly while `ss_n` is low.
- R11: Only one slave can be selected: `ss_n` is low only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 5 | Frame length in bits (4..16) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | 8 | Half-period of the serial clock in system clocks |
| cfg_rx_dly | input | 3 | rxd capture delay in system clocks |
| start | input | 1 | Begin a transfer (taken when idle) |
| tx_word | input | 16 | Word to send, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 16 | Last received word, right-aligned |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| ss_oe_n | output | 1 | Active-low enable for select and data drivers |
| txd | output | 1 | Serial data to the slave |
| rxd | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with its default parameters: 16-bit data, an 8-bit divider and a 3-bit delay field. This makes every frame length from 4 to 16 and every capture delay from 0 to 7 reachable. Transfers use small dividers so that many frames fit in the run. The slave model returns rxd through a lag equal to the programmed delay, so only a capture at the right offset recovers the slave's word. The divider floor and the length clamps are driven directly.

// File: rtl/spi_delay_master.sv
`timescale 1ns/1ps
module spi_delay_master #(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 3,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DLY_W-1:0]  cfg_rx_dly,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              ss_n,
  output logic              ss_oe_n,
  output logic              txd,
  input  logic              rxd
);
  localparam int EDGE_W = LEN_W + 1;
  localparam int PIPE_W = (1 << DLY_W) - 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} state_t;
  state_t st;

  logic [DIV_W-1:0]  div_q, cnt;
  logic [LEN_W-1:0]  len_q;
  logic              cpha_q;
  logic [DLY_W-1:0]  dly_q;
  logic [EDGE_W-1:0] edge_n;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [PIPE_W-1:0] pipe;

  logic [LEN_W-1:0]  len_in;
  logic [DIV_W-1:0]  div_in;
  logic [DATA_W-1:0] aligned;
  logic [EDGE_W-1:0] k;
  logic              go, tick, odd, last, samp_edge, shift_edge, capture, tail_done;
  logic [PIPE_W:0]   pipe_ext;
  logic [PIPE_W-1:0] mask;

  assign len_in = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                  (cfg_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : cfg_len;
  assign div_in  = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
  assign aligned = tx_word << (LEN_W'(DATA_W) - len_in);

  assign go    = start && (st == S_IDLE);
  assign tick  = (st == S_RUN) && (cnt == div_q - 1'b1);
  assign k     = edge_n + 1'b1;
  assign odd   = k[0];
  assign last  = (k == {len_q, 1'b0});
  assign samp_edge  = tick && (cpha_q ? !odd : odd);
  assign shift_edge = tick && (cpha_q ? odd : (!odd && !last));

  assign pipe_ext  = {pipe, samp_edge};
  assign capture   = pipe_ext[dly_q];
  assign mask      = (PIPE_W'(1) << dly_q) - PIPE_W'(1);
  assign tail_done = (cnt >= div_q - 1'b1) && !(|(pipe & mask));

  assign busy    = (st != S_IDLE);
  assign ss_oe_n = ss_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_q   <= DIV_W'(2);
      cnt     <= '0;
      len_q   <= LEN_W'(MIN_LEN);
      cpha_q  <= 1'b0;
      dly_q   <= '0;
      edge_n  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      pipe    <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      ss_n    <= 1'b1;
      txd     <= 1'b0;
    end else begin
      done <= 1'b0;
      pipe <= pipe_ext[PIPE_W-1:0];
      if (capture) rx_sh <= {rx_sh[DATA_W-2:0], rxd};
      case (st)
        S_IDLE: begin
          sclk <= cfg_cpol;
          if (go) begin
            len_q  <= len_in;
            div_q  <= div_in;
            cpha_q <= cfg_cpha;
            dly_q  <= cfg_rx_dly;
            cnt    <= '0;
            edge_n <= '0;
            rx_sh  <= '0;
            pipe   <= '0;
            ss_n   <= 1'b0;
            st     <= S_RUN;
            if (cfg_cpha) begin
              tx_sh <= aligned;
              txd   <= 1'b0;
            end else begin
              tx_sh <= aligned << 1;
              txd   <= aligned[DATA_W-1];
            end
          end
        end
        S_RUN: begin
          if (tick) begin
            cnt    <= '0;
            sclk   <= ~sclk;
            edge_n <= k;
            if (shift_edge) begin
              txd   <= tx_sh[DATA_W-1];
              tx_sh <= tx_sh << 1;
            end
            if (last) st <= S_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (tail_done) begin
            ss_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_sh;
            txd     <= 1'b0;
            st      <= S_IDLE;
          end else if (cnt < div_q - 1'b1) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_delay_master_chk.sv
`timescale 1ns/1ps
module spi_delay_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ss_n,
  input logic              ss_oe_n,
  input logic              sclk,
  input logic              cfg_cpol,
  input logic [DATA_W-1:0] rx_word
);
  assert_idle_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> (sclk == $past(cfg_cpol)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);

  assert_done_high_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ss_n);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> done);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !ss_n);

  assert_oe_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe_n == ss_n);

  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy);
endmodule

bind spi_delay_master spi_delay_master_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_spi_delay_master.sv
`timescale 1ns/1ps
module test_spi_delay_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic [2:0]  cfg_rx_dly = 3'd0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic        busy, done, sclk, ss_n, ss_oe_n, txd;
  logic [15:0] rx_word;
  logic        rxd = 1'b0;

  always #2.5 clk = ~clk;

  spi_delay_master i_spi_delay_master (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cfg_rx_dly(cfg_rx_dly),
    .start(start), .tx_word(tx_word), .busy(busy), .done(done),
    .rx_word(rx_word), .sclk(sclk), .ss_n(ss_n), .ss_oe_n(ss_oe_n),
    .txd(txd), .rxd(rxd));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: answers with a lag of s_lag system clocks on rxd
  logic [15:0] s_word = '0, s_rx = '0;
  int          s_len = 8, s_lag = 0, s_idx = 0, s_edges = 0;
  bit          s_cpol = 0, s_cpha = 0;
  bit          p_sclk = 0, p_ss = 1, raw = 0, lead = 0;
  logic [7:0]  line = '0;
  int          oe_bad = 0, sel_bad = 0;

  always @(negedge clk) begin
    line = {line[6:0], raw};
    if (ss_oe_n != ss_n) oe_bad++;
    if (!ss_n && !busy) sel_bad++;
    if (p_ss && !ss_n) begin
      s_edges = 0;
      s_rx = '0;
      if (!s_cpha) begin raw = s_word[s_len-1]; s_idx = s_len - 2; end
      else s_idx = s_len - 1;
    end else if (!ss_n && sclk != p_sclk) begin
      s_edges++;
      lead = (sclk != s_cpol);
      if (s_cpha ? lead : !lead) begin
        if (s_idx >= 0) begin raw = s_word[s_idx]; s_idx--; end
      end else s_rx = {s_rx[14:0], txd};
    end
    rxd = (s_lag == 0) ? raw : line[s_lag-1];
    p_sclk = sclk;
    p_ss = ss_n;
  end

  function automatic logic [15:0] lmask(input int len);
    return 16'((32'h1 << len) - 1);
  endfunction

  function automatic int exp_lat(input int len, input int div, input bit cpha, input int dly);
    int a = (2*len + 1) * div;
    int s = cpha ? 2*len*div : (2*len - 1) * div;
    return (a > s + dly + 1) ? a : s + dly + 1;
  endfunction

  task automatic xfer(input int lcfg, input int len, input bit cpol, input bit cpha,
                      input int dcfg, input int div, input int dly,
                      input logic [15:0] tw, input logic [15:0] sw, input bit poke);
    int cyc;
    @(negedge clk);
    cfg_len = 5'(lcfg); cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_div = 8'(dcfg); cfg_rx_dly = 3'(dly);
    s_word = sw; s_len = len; s_cpol = cpol; s_cpha = cpha; s_lag = dly;
    @(negedge clk); @(negedge clk);
    chk(sclk == cpol, "R2 idle clock level", sclk, cpol);
    chk(ss_n == 1'b1, "R2 idle select", ss_n, 1);
    tx_word = tw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (poke && cyc == 5) begin start = 1'b1; tx_word = ~tw; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == exp_lat(len, div, cpha, dly) + 1, "R8/R6 done latency", cyc, exp_lat(len, div, cpha, dly) + 1);
    chk(rx_word == (sw & lmask(len)), cpha ? "R4/R5/R7 received word" : "R3/R5/R7 received word",
        rx_word, sw & lmask(len));
    chk(s_rx == (tw & lmask(len)), poke ? "R9 word seen by slave" : (cpha ? "R4/R5 word seen by slave" : "R3/R5 word seen by slave"),
        s_rx, tw & lmask(len));
    chk(s_edges == 2*len, "R1 serial edge count", s_edges, 2*len);
    @(negedge clk);
    chk(done == 1'b0, "R8 done is one cycle", done, 0);
    chk(ss_n == 1'b1 && busy == 1'b0, "R8 deselected and idle", {ss_n, busy}, 2);
    chk(sclk == cpol, "R2 clock returned to idle", sclk, cpol);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7351);
    chk(ss_n == 1'b1 || !rst_n, "R2 select before reset", ss_n, 1);
    repeat (3) @(negedge clk);
    chk(ss_n == 1'b1 && busy == 1'b0 && done == 1'b0 && rx_word == '0, "R2 reset state",
        {ss_n, busy, done}, 4);
    rst_n = 1'b1;
    // directed corners
    xfer(4, 4, 0, 0, 2, 2, 7, 16'h000A, 16'h0005, 0);   // R7 max delay, short frame
    xfer(16, 16, 1, 1, 2, 2, 0, 16'hBEEF, 16'hC0DE, 0); // R7 zero delay, full frame
    xfer(2, 4, 0, 1, 3, 3, 3, 16'hFFF9, 16'h000C, 0);   // R1 low clamp
    xfer(25, 16, 1, 0, 4, 4, 2, 16'h8001, 16'h7FFE, 0); // R1 high clamp
    xfer(8, 8, 0, 0, 0, 2, 1, 16'h005A, 16'h00A5, 0);   // R6 divider floor
    xfer(8, 8, 1, 1, 1, 2, 5, 16'h00C3, 16'h003C, 0);   // R6 divider floor
    xfer(12, 12, 0, 1, 5, 5, 4, 16'h0ABC, 16'h0123, 1); // R9 start while busy
    // constrained random
    for (int i = 0; i < 40; i++) begin
      int len, div, dly;
      bit cp, ch;
      len = 4 + int'($urandom_range(0, 12));
      div = 2 + int'($urandom_range(0, 7));
      dly = int'($urandom_range(0, 7));
      cp = 1'($urandom_range(0, 1));
      ch = 1'($urandom_range(0, 1));
      xfer(len, len, cp, ch, div, div, dly, 16'($urandom), 16'($urandom), (i % 7) == 3);
    end
    chk(oe_bad == 0, "R10 output enable tracks select", oe_bad, 0);
    chk(sel_bad == 0, "R11 select only while busy", sel_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule